// File: doc/BRIEF.md
# Memory Controller Event Counter Bank

This block counts events inside a memory controller. It has a bank of general event counters and one wide cycle counter, and all of them sit behind a simple 32-bit register port. Each general counter has an enable bit and an event number. While the bank runs, a general counter adds one in each clock where the event strobe it has chosen is high. The event strobes are single-cycle inputs, up to 64 of them.

Software starts, stops and clears the whole bank through one control register, and it reads the running state back from a state register. It can give any general counter a starting value without disturbing the others. To do that it first writes a target code to the test register and then writes the value to the preload register. When a general counter wraps, it raises a one-cycle pulse on its own overflow output line, and a separate interrupt block picks that pulse up.

Writes take effect at the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`.

Top module: `pmu_evt_bank`

## Requirements
- R1: After `rst_n` is released, all general counters, both cycle-counter words and the state register (0x004) read 0.
- R2: A write to the control register (0x000) with bit 0 set and bits 2:1 clear starts the bank, and the state register then reads 1. A write with bit 1 set stops the bank, and the state register then reads 0. If bits 0 and 1 are written together, stop wins.
- R3: A control write with bit 2 set does three things: it clears every general counter and the cycle counter to 0, and it leaves the bank stopped. It does this even when bit 0 is set in the same write.
- R4: Counter n is configured in the 8-bit lane at bit 8*(n mod 4) of the select register at 0x020 + 4*(n/4). In that lane, bit 7 is the enable and bits 5:0 are the event number. Reading the register back returns what was written, except that bit 6 of every lane reads 0. A lane of zero disables the counter.
- R5: While the bank runs, an enabled counter adds one at each clock edge where `events[sel]` is high. It ignores every other strobe. While the bank is stopped, or while its lane is disabled, it holds its value.
- R6: The cycle counter is 56 bits wide and adds one every clock while the bank runs. Address 0x010 returns bits 55:32 with bits 31:24 reading 0. Address 0x014 returns bits 31:0.
- R7: First write 19+n to the test register (0x008). A following write to the preload register (0x00C) then loads general counter n with the written value, and the load wins over an increment at the same edge. The preload write is ignored when the test register holds 0 or any code outside 19..34.
- R8: A general counter wraps from 0xFFFFFFFF to 0. In the cycle where it reads 0 after the wrap, `ovf_pulse[n]` is high, and only in that one cycle.
- R9: General counter n reads at address 0x040 + 4*n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | 32 | Register read data (combinational) |
| events | input | 64 | Single-cycle event strobes |
| ovf_pulse | output | 16 | Per-counter wrap pulse |

## Verification
All sixteen counters run at once, each watching its own event, while a mixed event vector changes every cycle. A counter that picked the wrong strobe, or that counted strobes it should ignore, then ends with a visibly different total. A second pass disables the odd lanes, which separates the enable bit from the event selector. Every counter in turn is preloaded to all ones and given one strobe, which exposes a wrong target decode, a missing wrap, or a pulse on the wrong line. Combined control writes and a preload that lands on the same edge as an increment settle each of the priority rules.

// File: rtl/pmu_evt_pkg.sv
package pmu_evt_pkg;
    localparam int ADDR_W            = 12;
    localparam int EVT_SEL_W         = 6;
    localparam int LANE_W            = 8;
    localparam int LANES_PER_REG     = 4;
    localparam int PRELOAD_CODE_BASE = 19;

    localparam int CTRL_START = 0;
    localparam int CTRL_STOP  = 1;
    localparam int CTRL_CLEAR = 2;

    localparam logic [ADDR_W-1:0] OFF_CTRL     = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_STATE    = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_TEST     = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_PRELOAD  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_CYC_HI   = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_CYC_LO   = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_SEL_BASE = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_CNT_BASE = 12'h040;

    typedef struct packed {
        logic                 en;
        logic [EVT_SEL_W-1:0] evt;
    } lane_cfg_t;
endpackage

// File: rtl/pmu_gen_counter.sv
module pmu_gen_counter
    import pmu_evt_pkg::*;
#(
    parameter int CTR_W   = 32,
    parameter int NUM_EVT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               clear,
    input  logic               load,
    input  logic [CTR_W-1:0]   load_val,
    input  lane_cfg_t          cfg,
    input  logic [NUM_EVT-1:0] events,
    output logic [CTR_W-1:0]   count,
    output logic               ovf
);
    typedef struct packed {
        logic [CTR_W-1:0] cnt;
        logic             ovf;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        hit      = run && cfg.en && events[cfg.evt];
        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (load) begin
            st_d.cnt = load_val;
        end else if (hit) begin
            st_d.cnt = st_q.cnt + CTR_W'(1);
            st_d.ovf = &st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign ovf   = st_q.ovf;
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
    parameter int CYC_W = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    output logic [CYC_W-1:0] count
);
    logic [CYC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)    cnt_d = '0;
        else if (run) cnt_d = cnt_q + CYC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/pmu_evt_bank.sv
module pmu_evt_bank
    import pmu_evt_pkg::*;
#(
    parameter int NUM_CTR = 16,
    parameter int CTR_W   = 32,
    parameter int CYC_W   = 56
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [11:0]        wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [11:0]        rd_addr,
    output logic [31:0]        rd_data,
    input  logic [63:0]        events,
    output logic [NUM_CTR-1:0] ovf_pulse
);
    localparam int NUM_EVT      = 1 << EVT_SEL_W;
    localparam int NUM_SEL_REGS = (NUM_CTR + LANES_PER_REG - 1) / LANES_PER_REG;

    typedef struct packed {
        logic                    run;
        logic [7:0]              test_sel;
        lane_cfg_t [NUM_CTR-1:0] cfg;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     wr_ctrl, wr_test, wr_pre, clear_all;
    logic [NUM_CTR-1:0]            load_vec;
    logic [NUM_CTR-1:0][CTR_W-1:0] cnt_w;
    logic [CYC_W-1:0]              cyc_w;

    always_comb begin
        wr_ctrl   = wr_en && (wr_addr == OFF_CTRL);
        wr_test   = wr_en && (wr_addr == OFF_TEST);
        wr_pre    = wr_en && (wr_addr == OFF_PRELOAD);
        clear_all = wr_ctrl && wr_data[CTRL_CLEAR];
        st_d      = st_q;
        if (wr_ctrl) begin
            if (wr_data[CTRL_CLEAR] || wr_data[CTRL_STOP]) st_d.run = 1'b0;
            else if (wr_data[CTRL_START])                  st_d.run = 1'b1;
        end
        if (wr_test) st_d.test_sel = wr_data[7:0];
        for (int r = 0; r < NUM_SEL_REGS; r++) begin
            if (wr_en && (wr_addr == OFF_SEL_BASE + ADDR_W'(4 * r))) begin
                for (int l = 0; l < LANES_PER_REG; l++) begin
                    if (r * LANES_PER_REG + l < NUM_CTR) begin
                        st_d.cfg[r*LANES_PER_REG+l].en  = wr_data[LANE_W*l+7];
                        st_d.cfg[r*LANES_PER_REG+l].evt = wr_data[LANE_W*l +: EVT_SEL_W];
                    end
                end
            end
        end
        for (int n = 0; n < NUM_CTR; n++) begin
            load_vec[n] = wr_pre && (st_q.test_sel == 8'(PRELOAD_CODE_BASE + n));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        pmu_gen_counter #(.CTR_W(CTR_W), .NUM_EVT(NUM_EVT)) ctr_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (st_q.run),
            .clear    (clear_all),
            .load     (load_vec[g]),
            .load_val (wr_data[CTR_W-1:0]),
            .cfg      (st_q.cfg[g]),
            .events   (events[NUM_EVT-1:0]),
            .count    (cnt_w[g]),
            .ovf      (ovf_pulse[g])
        );
    end

    pmu_cycle_counter #(.CYC_W(CYC_W)) cyc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.run),
        .clear (clear_all),
        .count (cyc_w)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFF_STATE:  rd_data = {31'd0, st_q.run};
            OFF_TEST:   rd_data = {24'd0, st_q.test_sel};
            OFF_CYC_HI: rd_data = 32'(cyc_w >> 32);
            OFF_CYC_LO: rd_data = cyc_w[31:0];
            default:    rd_data = '0;
        endcase
        for (int r = 0; r < NUM_SEL_REGS; r++) begin
            if (rd_addr == OFF_SEL_BASE + ADDR_W'(4 * r)) begin
                for (int l = 0; l < LANES_PER_REG; l++) begin
                    if (r * LANES_PER_REG + l < NUM_CTR) begin
                        rd_data[LANE_W*l +: LANE_W] = {st_q.cfg[r*LANES_PER_REG+l].en, 1'b0,
                                                      st_q.cfg[r*LANES_PER_REG+l].evt};
                    end
                end
            end
        end
        for (int n = 0; n < NUM_CTR; n++) begin
            if (rd_addr == OFF_CNT_BASE + ADDR_W'(4 * n)) rd_data = 32'(cnt_w[n]);
        end
    end
endmodule

// File: rtl/pmu_evt_bank_chk.sv
module pmu_evt_bank_chk
    import pmu_evt_pkg::*;
#(
    parameter int NUM_CTR = 16,
    parameter int CTR_W   = 32,
    parameter int CYC_W   = 56
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [11:0]                   wr_addr,
    input logic [31:0]                   wr_data,
    input logic                          run,
    input logic [NUM_CTR-1:0][CTR_W-1:0] cnt,
    input logic [CYC_W-1:0]              cyc,
    input logic [NUM_CTR-1:0]            ovf
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == OFF_CTRL);

    p_clear_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && wr_data[CTRL_CLEAR] |=> !run && (cyc == '0) && (cnt == '0));

    p_start_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && (wr_data[2:0] == 3'b001) |=> run);

    p_stop_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && wr_data[CTRL_STOP] |=> !run);

    p_cycle_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run && !ctrl_wr |=> cyc == $past(cyc) + CYC_W'(1));

    p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !wr_en |=> $stable(cnt) && $stable(cyc));

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ovf
        p_ovf_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[k] |-> cnt[k] == '0);
        p_ovf_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[k] |=> !ovf[k]);
    end
endmodule

bind pmu_evt_bank pmu_evt_bank_chk #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .CYC_W   (CYC_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .run     (st_q.run),
    .cnt     (cnt_w),
    .cyc     (cyc_w),
    .ovf     (ovf_pulse)
);

// File: tb/pmu_evt_bank_tb_top.sv
module pmu_evt_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] events = '0;
    logic [15:0] ovf_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_cnt [16];

    always #4 clk = ~clk;

    pmu_evt_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .events(events), .ovf_pulse(ovf_pulse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // called at a falling edge; write lands at the next rising edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic tick(input logic [63:0] ev);
        events = ev; @(posedge clk); @(negedge clk);
    endtask

    function automatic int evt_of(input int n);
        return (7 * n + 1) % 64;
    endfunction

    task automatic program_lanes(input logic [15:0] en_mask, input bit own_idx);
        for (int r = 0; r < 4; r++) begin
            logic [31:0] d = '0;
            for (int l = 0; l < 4; l++) begin
                int n = 4 * r + l;
                d[8*l +: 8] = {en_mask[n], 1'b0, 6'(own_idx ? n : evt_of(n))};
            end
            wr(12'h020 + 12'(4 * r), d);
        end
    endtask

    task automatic run_phase(input logic [15:0] en_mask, input int seed);
        logic [31:0] v;
        program_lanes(en_mask, 1'b0);
        wr(12'h000, 32'h1);
        for (int c = 0; c < 48; c++) begin
            logic [63:0] ev;
            ev = {32'(c * 32'h9E3779B9 + seed), 32'((c + seed) * 32'h85EBCA6B) ^ 32'(c << 7)};
            for (int n = 0; n < 16; n++)
                if (en_mask[n] && ev[evt_of(n)]) exp_cnt[n] = exp_cnt[n] + 1;
            tick(ev);
        end
        events = '0;
        wr(12'h000, 32'h2);
        for (int n = 0; n < 16; n++) begin
            rd(12'h040 + 12'(4 * n), v);
            check($sformatf("R5 R9 counter %0d total", n), v, exp_cnt[n]);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int n = 0; n < 16; n++) begin
            rd(12'h040 + 12'(4 * n), v);
            check("R1 counter after reset", v, 32'h0);
        end
        rd(12'h004, v); check("R1 state after reset", v, 32'h0);
        rd(12'h010, v); check("R1 cycle hi after reset", v, 32'h0);
        rd(12'h014, v); check("R1 cycle lo after reset", v, 32'h0);

        // R4 lane readback, bit 6 of each lane reads 0
        for (int r = 0; r < 4; r++) begin
            wr(12'h020 + 12'(4 * r), 32'hFFFFFFFF);
            rd(12'h020 + 12'(4 * r), v);
            check("R4 select all ones", v, 32'hBFBFBFBF);
            wr(12'h020 + 12'(4 * r), 32'h5AC33C00 + 32'(r * 17));
            rd(12'h020 + 12'(4 * r), v);
            check("R4 select pattern", v, (32'h5AC33C00 + 32'(r * 17)) & 32'hBFBFBFBF);
        end

        // R2 start / stop / state register
        wr(12'h000, 32'h1); rd(12'h004, v); check("R2 state after start", v, 32'h1);
        wr(12'h000, 32'h2); rd(12'h004, v); check("R2 state after stop", v, 32'h0);
        wr(12'h000, 32'h1); wr(12'h000, 32'h3);
        rd(12'h004, v); check("R2 stop wins over start", v, 32'h0);

        // R3 clear wins over start
        wr(12'h000, 32'h5);
        rd(12'h004, v); check("R3 clear with start leaves stopped", v, 32'h0);
        rd(12'h014, v); check("R3 cycle cleared", v, 32'h0);

        // R6 cycle counter: start at edge P0, stop at P(W+1)
        wr(12'h000, 32'h1);
        repeat (20) @(negedge clk);
        wr(12'h000, 32'h2);
        rd(12'h014, v); check("R6 cycle lo after run", v, 32'd21);
        rd(12'h010, v); check("R6 cycle hi upper bits", v, 32'h0);
        repeat (5) @(negedge clk);
        rd(12'h014, v); check("R6 cycle holds when stopped", v, 32'd21);

        // R5 counting, all lanes then even lanes only
        for (int n = 0; n < 16; n++) exp_cnt[n] = 0;
        wr(12'h000, 32'h4);
        run_phase(16'hFFFF, 3);
        run_phase(16'h5555, 11);
        for (int c = 0; c < 6; c++) tick('1);
        events = '0;
        rd(12'h040, v); check("R5 stopped bank ignores strobes", v, exp_cnt[0]);

        // R7 preload ignored with test code 0, 18 and 35
        wr(12'h008, 32'h0); wr(12'h00C, 32'h12345678);
        rd(12'h040, v); check("R7 preload ignored code 0", v, exp_cnt[0]);
        wr(12'h008, 32'd18); wr(12'h00C, 32'h12345678);
        rd(12'h040, v); check("R7 preload ignored code 18", v, exp_cnt[0]);
        wr(12'h008, 32'd35); wr(12'h00C, 32'h12345678);
        rd(12'h07C, v); check("R7 preload ignored code 35", v, exp_cnt[15]);

        // R8 wrap on every counter, lane n watches event n
        program_lanes(16'hFFFF, 1'b1);
        for (int n = 0; n < 16; n++) begin
            wr(12'h008, 32'(19 + n)); wr(12'h00C, 32'hFFFFFFFF); wr(12'h008, 32'h0);
            rd(12'h040 + 12'(4 * n), v); check("R7 preload loads target", v, 32'hFFFFFFFF);
            wr(12'h000, 32'h1);
            tick(64'(1) << n);
            events = '0;
            check($sformatf("R8 ovf pulse counter %0d", n), 32'(ovf_pulse), 32'(16'(1) << n));
            rd(12'h040 + 12'(4 * n), v); check("R8 wrapped to zero", v, 32'h0);
            tick('0);
            check("R8 ovf lasts one cycle", 32'(ovf_pulse), 32'h0);
            wr(12'h000, 32'h2);
        end

        // R7 preload wins over increment on the same edge
        wr(12'h008, 32'd24);
        wr(12'h000, 32'h1);
        events = 64'(1) << 5;
        wr(12'h00C, 32'h00ABCDEF);
        events = '0;
        rd(12'h054, v); check("R7 preload beats increment", v, 32'h00ABCDEF);
        tick(64'(1) << 5);
        events = '0;
        rd(12'h054, v2); check("R5 counts after preload", v2, 32'h00ABCDF0);
        wr(12'h000, 32'h2);
        wr(12'h008, 32'h0);

        // R3 clear zeroes every counter
        wr(12'h000, 32'h4);
        for (int n = 0; n < 16; n++) begin
            rd(12'h040 + 12'(4 * n), v);
            check("R3 counter cleared", v, 32'h0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule